// File: doc/BRIEF.md
# Set/Clear-Enable Interrupt Controller

This block gathers a parameterized number of level-sensitive interrupt lines (a multiple of 32) and presents them to a single processor as one interrupt request. It is reached through a plain 32-bit register bus with a write strobe, a read strobe, a byte address and read data that returns one cycle after the read strobe. Each line has an enable bit, changed only by writing ones into a set-enable or a clear-enable bank, and an 8-bit priority. A priority mask on the processor side blocks every line whose priority value is not strictly below it.

Delivery is gated by two separate enable flags, one for the line-collection side and one for the processor side. The processor claims the best pending line by reading an acknowledge register, which marks that line active. It retires the line by writing its number to an end-of-interrupt register. An active line is not offered again until it is retired. When nothing qualifies, the acknowledge read returns the spurious number 1023 and changes nothing.

Top module: `irqc_top`

## Requirements
- R1: A read of the type register (byte address 0x004) returns N in bits [4:0] and zero elsewhere, where N = NUM_WORDS-1, so the number of lines is (N+1)*32.
- R2: Line i's enable sits in enable word i/32 at bit i%32. Enable word k is read at 0x100+4k and also at 0x180+4k, and every enable is 0 after reset.
- R3: A write to 0x100+4k enables each line whose data bit is 1 and leaves lines whose bit is 0 as they were.
- R4: A write to 0x180+4k disables each line whose data bit is 1 and leaves lines whose bit is 0 as they were.
- R5: Bit 0 of the distributor control register (0x000) and bit 0 of the processor control register (0x800) must both be 1 for irq_o to rise or for an acknowledge read to claim a line. With either flag at 0, the acknowledge read returns 1023. irq_o is registered and follows its inputs one cycle later.
- R6: Line i's 8-bit priority sits in byte i%4 of the priority word at 0x200+4*(i/4). A line qualifies only if its priority is strictly below the mask in bits [7:0] of 0x804, so a mask of 0xFF passes every priority below 0xFF. The lowest priority value wins, and a tie goes to the lowest line number.
- R7: The acknowledge word (read at 0x808) carries the line number in bits [9:0], the processor number 0 in bits [12:10] and zeros above. It appears on bus_rdata in the cycle after the read strobe.
- R8: An acknowledge read with no qualifying enabled pending line returns 1023 and changes no state.
- R9: An acknowledge read that claims a line makes it active. An active line is never offered until it is retired.
- R10: Writing a line number in bits [9:0] to 0x80C retires that line if it is active. Naming a line that is not active has no effect.
- R11: A line is pending only while its input is high. A line dropped before the acknowledge read is not offered.
- R12: After reset, irq_o is 0, bus_rdata is 0, both control flags and the mask are 0, and no line is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_lines | input | NUM_WORDS*32 | Level-sensitive interrupt inputs |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with NUM_WORDS = 2, which gives 64 lines. That is two enable words, sixteen priority words and a padded 64-leaf selection tree, so line numbers above 31 check the word and bit split of the enables. Ties between lines in different enable words check the lowest-number rule across the tree's top split. Random priorities, masks, enable words and retire numbers, some naming lines that are not active, are run against a bench model of the selection rule. Directed cases cover the mask boundary at 0xFF, each enable flag alone, and a line dropped just before its claim.

// File: rtl/irqc_pkg.sv
// Package: shared constants, address map and register decode for the
// interrupt controller. Assumes a 12-bit byte address with word alignment.
package irqc_pkg;
    localparam int BUS_W       = 32;
    localparam int ADDR_W      = 12;
    localparam int PRIO_W      = 8;
    localparam int LANE_PER_W  = BUS_W / PRIO_W;
    localparam int ID_FIELD_W  = 10;
    localparam int CPU_FIELD_W = 3;
    localparam logic [ID_FIELD_W-1:0] SPURIOUS_ID = 10'd1023;

    localparam logic [ADDR_W-1:0] A_DIST_CTRL = 12'h000;
    localparam logic [ADDR_W-1:0] A_TYPE      = 12'h004;
    localparam logic [ADDR_W-1:0] A_SET_BASE  = 12'h100;
    localparam logic [ADDR_W-1:0] A_CLR_BASE  = 12'h180;
    localparam logic [ADDR_W-1:0] A_PRIO_BASE = 12'h200;
    localparam logic [ADDR_W-1:0] A_PRIO_END  = 12'h600;
    localparam logic [ADDR_W-1:0] A_CPU_CTRL  = 12'h800;
    localparam logic [ADDR_W-1:0] A_PMASK     = 12'h804;
    localparam logic [ADDR_W-1:0] A_ACK       = 12'h808;
    localparam logic [ADDR_W-1:0] A_EOI       = 12'h80C;

    typedef enum logic [3:0] {
        RG_NONE, RG_DIST_CTRL, RG_TYPE, RG_SET, RG_CLR, RG_PRIO,
        RG_CPU_CTRL, RG_PMASK, RG_ACK, RG_EOI
    } region_e;

    // Map a byte address to the register region it selects.
    function automatic region_e decode_region(input logic [ADDR_W-1:0] a);
        region_e r;
        r = RG_NONE;
        if (a[1:0] == 2'b00) begin
            if (a == A_DIST_CTRL)                      r = RG_DIST_CTRL;
            else if (a == A_TYPE)                      r = RG_TYPE;
            else if (a[11:7] == A_SET_BASE[11:7])      r = RG_SET;
            else if (a[11:7] == A_CLR_BASE[11:7])      r = RG_CLR;
            else if (a >= A_PRIO_BASE && a < A_PRIO_END) r = RG_PRIO;
            else if (a == A_CPU_CTRL)                  r = RG_CPU_CTRL;
            else if (a == A_PMASK)                     r = RG_PMASK;
            else if (a == A_ACK)                       r = RG_ACK;
            else if (a == A_EOI)                       r = RG_EOI;
        end
        return r;
    endfunction
endpackage

// File: rtl/irqc_enable_bank.sv
// Module: per-line enable bits, packed 32 per word.
// A set write ORs ones in and a clear write removes ones. Assumes at most
// one of set_we / clr_we is high in a cycle (distinct addresses).
module irqc_enable_bank #(
    parameter int NUM_WORDS = 2,
    localparam int LINES    = NUM_WORDS * 32,
    localparam int IDX_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [IDX_W-1:0] word_idx,
    input  logic [31:0]      wdata,
    output logic [LINES-1:0] en
);
    // Apply set or clear to the addressed enable word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= '0;
        end else begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (int'(word_idx) == w) begin
                    if (set_we)      en[w*32 +: 32] <= en[w*32 +: 32] | wdata;
                    else if (clr_we) en[w*32 +: 32] <= en[w*32 +: 32] & ~wdata;
                end
            end
        end
    end
endmodule

// File: rtl/irqc_prio_bank.sv
// Module: 8-bit priority per line, four lines per 32-bit word.
// Line i occupies byte i%4 of word i/4. Writes past the last word are dropped.
module irqc_prio_bank
    import irqc_pkg::*;
#(
    parameter int LINES      = 64,
    localparam int PWORDS    = LINES / LANE_PER_W,
    localparam int IDX_W     = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [IDX_W-1:0]        word_idx,
    input  logic [31:0]             wdata,
    output logic [LINES*PRIO_W-1:0] prio_flat
);
    // Store a whole priority word when it is addressed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_flat <= '0;
        end else if (we) begin
            for (int k = 0; k < PWORDS; k++) begin
                if (int'(word_idx) == k) prio_flat[k*32 +: 32] <= wdata;
            end
        end
    end
endmodule

// File: rtl/irqc_select_tree.sv
// Module: balanced comparison tree picking the eligible line with the
// lowest priority value; on equal values the lower line number wins.
// Assumes LINES >= 2. Purely combinational.
module irqc_select_tree
    import irqc_pkg::*;
#(
    parameter int LINES   = 64,
    localparam int ID_W   = $clog2(LINES),
    localparam int PAD    = 1 << ID_W,
    localparam int NODES  = 2 * PAD - 1
) (
    input  logic [LINES-1:0]        elig,
    input  logic [LINES*PRIO_W-1:0] prio_flat,
    output logic                    cand_valid,
    output logic [ID_W-1:0]         cand_id
);
    logic              nv [NODES];
    logic [PRIO_W-1:0] np [NODES];
    logic [ID_W-1:0]   ni [NODES];

    genvar g;
    // Leaves: one per line, padding leaves never valid.
    for (g = 0; g < PAD; g++) begin : g_leaf
        if (g < LINES) begin : g_real
            assign nv[PAD-1+g] = elig[g];
            assign np[PAD-1+g] = prio_flat[g*PRIO_W +: PRIO_W];
        end else begin : g_pad
            assign nv[PAD-1+g] = 1'b0;
            assign np[PAD-1+g] = '1;
        end
        assign ni[PAD-1+g] = ID_W'(g);
    end

    // Inner nodes: the left child holds lower numbers and wins ties.
    for (g = 0; g < PAD - 1; g++) begin : g_node
        logic take_left;
        assign take_left = nv[2*g+1] && (!nv[2*g+2] || np[2*g+1] <= np[2*g+2]);
        assign nv[g] = nv[2*g+1] || nv[2*g+2];
        assign np[g] = take_left ? np[2*g+1] : np[2*g+2];
        assign ni[g] = take_left ? ni[2*g+1] : ni[2*g+2];
    end

    assign cand_valid = nv[0];
    assign cand_id    = ni[0];
endmodule

// File: rtl/irqc_cpu_port.sv
// Module: processor-side handshake. Tracks active lines, forms the
// acknowledge word, retires lines on end-of-interrupt and drives irq_o.
// Assumes cand_id names a line that is not active whenever cand_valid is 1.
module irqc_cpu_port
    import irqc_pkg::*;
#(
    parameter int LINES  = 64,
    localparam int ID_W  = $clog2(LINES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  deliver_ok,
    input  logic                  ack_rd,
    input  logic                  eoi_wr,
    input  logic [ID_FIELD_W-1:0] eoi_id,
    input  logic                  cand_valid,
    input  logic [ID_W-1:0]       cand_id,
    output logic                  ack_take,
    output logic [31:0]           ack_word,
    output logic [LINES-1:0]      active,
    output logic                  irq_o
);
    logic [LINES-1:0] set_v;
    logic [LINES-1:0] clr_v;

    assign ack_take = ack_rd && deliver_ok && cand_valid;

    // Acknowledge word: line number, processor number zero, or spurious.
    always_comb begin
        ack_word = '0;
        ack_word[ID_FIELD_W-1:0] = ack_take ? ID_FIELD_W'(cand_id) : SPURIOUS_ID;
    end

    // One-hot claim and retire vectors.
    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            set_v[i] = ack_take && (int'(cand_id) == i);
            clr_v[i] = eoi_wr && (int'(eoi_id) == i);
        end
    end

    // Active state: a claim in the same cycle outranks a retire.
    always_ff @(posedge clk) begin
        if (!rst_n) active <= '0;
        else        active <= (active & ~clr_v) | set_v;
    end

    // Registered request to the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= deliver_ok && cand_valid;
    end
endmodule

// File: rtl/irqc_top.sv
// Module: interrupt controller top. Decodes the register bus, holds the
// two control flags and the mask, qualifies lines and registers read data.
// Assumes NUM_WORDS between 1 and 31 and one bus access of each kind per cycle.
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_WORDS = 2,
    localparam int LINES    = NUM_WORDS * 32,
    localparam int ID_W     = $clog2(LINES),
    localparam int PWORDS   = LINES / LANE_PER_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [LINES-1:0]  irq_lines,
    output logic              irq_o
);
    region_e                 region;
    logic [4:0]              en_idx;
    logic [11:0]             prio_off;
    logic [7:0]              prio_idx;
    logic                    dist_en;
    logic                    cpu_en;
    logic [PRIO_W-1:0]       pmask;
    logic [LINES-1:0]        en;
    logic [LINES*PRIO_W-1:0] prio_flat;
    logic [LINES-1:0]        elig;
    logic [LINES-1:0]        active;
    logic                    cand_valid;
    logic [ID_W-1:0]         cand_id;
    logic                    ack_take;
    logic [31:0]             ack_word;
    logic [31:0]             rd_mux;

    assign region   = decode_region(bus_addr);
    assign en_idx   = bus_addr[6:2];
    assign prio_off = bus_addr - A_PRIO_BASE;
    assign prio_idx = prio_off[9:2];

    // Control flags and priority mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dist_en <= 1'b0;
            cpu_en  <= 1'b0;
            pmask   <= '0;
        end else if (bus_wr) begin
            if (region == RG_DIST_CTRL) dist_en <= bus_wdata[0];
            if (region == RG_CPU_CTRL)  cpu_en  <= bus_wdata[0];
            if (region == RG_PMASK)     pmask   <= bus_wdata[PRIO_W-1:0];
        end
    end

    irqc_enable_bank #(.NUM_WORDS(NUM_WORDS)) u_enables (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (bus_wr && region == RG_SET),
        .clr_we   (bus_wr && region == RG_CLR),
        .word_idx (en_idx),
        .wdata    (bus_wdata),
        .en       (en)
    );

    irqc_prio_bank #(.LINES(LINES)) u_prios (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_wr && region == RG_PRIO),
        .word_idx  (prio_idx),
        .wdata     (bus_wdata),
        .prio_flat (prio_flat)
    );

    // Per-line qualification: pending, enabled, not active, under the mask.
    genvar gl;
    for (gl = 0; gl < LINES; gl++) begin : g_elig
        assign elig[gl] = irq_lines[gl] && en[gl] && !active[gl]
                          && (prio_flat[gl*PRIO_W +: PRIO_W] < pmask);
    end

    irqc_select_tree #(.LINES(LINES)) u_select (
        .elig       (elig),
        .prio_flat  (prio_flat),
        .cand_valid (cand_valid),
        .cand_id    (cand_id)
    );

    irqc_cpu_port #(.LINES(LINES)) u_cpu (
        .clk        (clk),
        .rst_n      (rst_n),
        .deliver_ok (dist_en && cpu_en),
        .ack_rd     (bus_rd && region == RG_ACK),
        .eoi_wr     (bus_wr && region == RG_EOI),
        .eoi_id     (bus_wdata[ID_FIELD_W-1:0]),
        .cand_valid (cand_valid),
        .cand_id    (cand_id),
        .ack_take   (ack_take),
        .ack_word   (ack_word),
        .active     (active),
        .irq_o      (irq_o)
    );

    // Read data selection for the addressed register.
    always_comb begin
        rd_mux = '0;
        unique case (region)
            RG_DIST_CTRL: rd_mux[0] = dist_en;
            RG_CPU_CTRL:  rd_mux[0] = cpu_en;
            RG_PMASK:     rd_mux[PRIO_W-1:0] = pmask;
            RG_TYPE:      rd_mux[4:0] = 5'(NUM_WORDS - 1);
            RG_ACK:       rd_mux = ack_word;
            RG_SET, RG_CLR: begin
                for (int w = 0; w < NUM_WORDS; w++)
                    if (int'(en_idx) == w) rd_mux = en[w*32 +: 32];
            end
            RG_PRIO: begin
                for (int k = 0; k < PWORDS; k++)
                    if (int'(prio_idx) == k) rd_mux = prio_flat[k*32 +: 32];
            end
            default: rd_mux = '0;
        endcase
    end

    // Registered read data, one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/irqc_checker.sv
// Module: property checker for irqc_top, attached by bind below.
// Observes ports and the signals passed between the top's sub-blocks.
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int LINES  = 64,
    localparam int ID_W  = $clog2(LINES)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wr,
    input logic                    bus_rd,
    input logic [11:0]             bus_addr,
    input logic [31:0]             bus_wdata,
    input logic [31:0]             bus_rdata,
    input logic [LINES-1:0]        irq_lines,
    input logic                    irq_o,
    input logic                    dist_en,
    input logic                    cpu_en,
    input logic [PRIO_W-1:0]       pmask,
    input logic [LINES-1:0]        en,
    input logic [LINES*PRIO_W-1:0] prio_flat,
    input logic [LINES-1:0]        active,
    input logic                    cand_valid,
    input logic [ID_W-1:0]         cand_id,
    input logic                    ack_take
);
    p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(dist_en && cpu_en));

    p_cand_not_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> !active[cand_id]);

    p_cand_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> (irq_lines[cand_id] && en[cand_id]));

    p_cand_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> (prio_flat[cand_id*PRIO_W +: PRIO_W] < pmask));

    p_claim_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> active[$past(cand_id)]);

    p_ack_format_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && bus_addr == A_ACK) |-> (bus_rdata[31:ID_FIELD_W] == '0));

    p_spurious_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_ACK && !ack_take && !bus_wr) |=> $stable(active));

    p_eoi_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EOI && !bus_rd &&
         (int'(bus_wdata[ID_FIELD_W-1:0]) >= LINES || !active[bus_wdata[ID_W-1:0]]))
        |=> $stable(active));
endmodule

bind irqc_top irqc_checker #(.LINES(LINES)) u_irqc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_lines  (irq_lines),
    .irq_o      (irq_o),
    .dist_en    (dist_en),
    .cpu_en     (cpu_en),
    .pmask      (pmask),
    .en         (en),
    .prio_flat  (prio_flat),
    .active     (active),
    .cand_valid (cand_valid),
    .cand_id    (cand_id),
    .ack_take   (ack_take)
);

// File: tb/test_irqc_top.sv
// Bench: directed corner cases plus seeded random traffic, checked
// against a behavioural model of enables, priorities and active lines.
module test_irqc_top;
    localparam int NW    = 2;
    localparam int NL    = NW * 32;
    localparam int SPUR  = 1023;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NL-1:0] lines_v = '0;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    bit       m_en  [NL];
    bit [7:0] m_pr  [NL];
    bit       m_act [NL];
    bit       m_dist = 1'b0;
    bit       m_cpu  = 1'b0;
    int       m_mask = 0;

    always #2.5 clk = ~clk;

    irqc_top #(.NUM_WORDS(NW)) i_irqc_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lines(lines_v), .irq_o(irq_o)
    );

    // Expected acknowledge number from the model.
    function automatic int exp_ack();
        int best = -1;
        if (!(m_dist && m_cpu)) return SPUR;
        for (int i = 0; i < NL; i++) begin
            if (lines_v[i] && m_en[i] && !m_act[i] && int'(m_pr[i]) < m_mask &&
                (best < 0 || m_pr[i] < m_pr[best])) best = i;
        end
        return (best < 0) ? SPUR : best;
    endfunction

    function automatic logic [31:0] en_word(int w);
        logic [31:0] v;
        for (int b = 0; b < 32; b++) v[b] = m_en[w*32 + b];
        return v;
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_set(input int w, input logic [31:0] d);
        bus_write(12'h100 + 12'(4*w), d);
        for (int b = 0; b < 32; b++) if (d[b]) m_en[w*32+b] = 1'b1;
    endtask

    task automatic do_clr(input int w, input logic [31:0] d);
        bus_write(12'h180 + 12'(4*w), d);
        for (int b = 0; b < 32; b++) if (d[b]) m_en[w*32+b] = 1'b0;
    endtask

    task automatic do_prio(input int line, input bit [7:0] v);
        logic [31:0] d;
        int k;
        m_pr[line] = v;
        k = line / 4;
        for (int j = 0; j < 4; j++) d[j*8 +: 8] = m_pr[k*4 + j];
        bus_write(12'h200 + 12'(4*k), d);
    endtask

    task automatic do_mask(input int v);
        bus_write(12'h804, 32'(v));
        m_mask = v;
    endtask

    task automatic do_ctrl(input bit d, input bit c);
        bus_write(12'h000, {31'b0, d});
        bus_write(12'h800, {31'b0, c});
        m_dist = d; m_cpu = c;
    endtask

    task automatic do_ack(input string tag, output int got);
        logic [31:0] d;
        int e;
        e = exp_ack();
        bus_read(12'h808, d);
        chk(d, 32'(e), tag);
        if (e != SPUR) m_act[e] = 1'b1;
        got = int'(d);
    endtask

    task automatic do_eoi(input int id);
        bus_write(12'h80C, 32'(id));
        if (id < NL) m_act[id] = 1'b0;
    endtask

    task automatic chk_irq(input string tag);
        @(negedge clk);
        chk({31'b0, irq_o}, {31'b0, (exp_ack() != SPUR)}, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int g;
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        for (int i = 0; i < NL; i++) begin m_en[i] = 0; m_pr[i] = 0; m_act[i] = 0; end
        repeat (3) @(negedge clk);
        // R12: reset state
        chk({31'b0, irq_o}, 32'd0, "R12 irq after reset");
        chk(bus_rdata, 32'd0, "R12 rdata after reset");
        rst_n = 1'b1;
        // R1: type register and line count
        bus_read(12'h004, d);
        chk(d, 32'(NW - 1), "R1 type field");
        chk(32'((d[4:0] + 1) * 32), 32'(NL), "R1 line count");
        // R2/R12: enables clear after reset
        bus_read(12'h100, d); chk(d, 32'd0, "R2 enable word0 reset");
        bus_read(12'h184, d); chk(d, 32'd0, "R2 enable word1 reset via clear bank");
        lines_v = '1;
        do_ack("R12 ack spurious after reset", g);

        // R3/R2: set semantics and bit position (line 37 -> word1 bit5)
        do_set(1, 32'h0000_0020);
        bus_read(12'h104, d); chk(d, 32'h0000_0020, "R2 line37 word1 bit5");
        do_set(1, 32'h0000_0101);
        bus_read(12'h184, d); chk(d, 32'h0000_0121, "R3 set keeps zero bits");
        do_set(0, 32'h0000_0222);
        // R4: clear semantics
        do_clr(1, 32'h0000_0100);
        bus_read(12'h104, d); chk(d, 32'h0000_0021, "R4 clear keeps zero bits");
        do_clr(0, 32'hFFFF_FFFF);
        do_clr(1, 32'hFFFF_FFFF);
        bus_read(12'h100, d); chk(d, 32'd0, "R4 all-ones clear word0");
        bus_read(12'h104, d); chk(d, 32'd0, "R4 all-ones clear word1");

        // R5: both enable flags required
        lines_v = '0;
        lines_v[5] = 1'b1; lines_v[9] = 1'b1; lines_v[40] = 1'b1;
        do_prio(5, 8'h40); do_prio(9, 8'h40); do_prio(40, 8'h40);
        do_set(0, 32'h0000_0220); do_set(1, 32'h0000_0100);
        do_mask(8'hFF);
        do_ctrl(1'b1, 1'b0);
        chk_irq("R5 irq low with processor flag off");
        chk({31'b0, irq_o}, 32'd0, "R5 irq low, one flag");
        do_ack("R5 ack spurious with one flag", g);
        do_ctrl(1'b0, 1'b1);
        do_ack("R5 ack spurious with other flag", g);
        do_ctrl(1'b1, 1'b1);
        chk_irq("R5 irq high with both flags");
        chk({31'b0, irq_o}, 32'd1, "R5 irq high literal");

        // R6/R7/R9: tie to lowest number, then next after claim
        do_ack("R6 tie lowest id", g); chk(32'(g), 32'd5, "R6 tie picks line 5");
        do_ack("R9 active not offered", g); chk(32'(g), 32'd9, "R9 next is line 9");
        // R10: retire of non-active line ignored
        do_eoi(40 - 1);
        do_eoi(1000);
        do_ack("R10 non-active retire ignored", g); chk(32'(g), 32'd40, "R6 line 40 across words");
        do_ack("R8 all active -> spurious", g); chk(32'(g), 32'(SPUR), "R8 spurious literal");
        // R10: retire re-offers line 5 (still high)
        do_eoi(5);
        do_ack("R10 retired line offered again", g); chk(32'(g), 32'd5, "R10 line 5 again");
        do_eoi(5); do_eoi(9); do_eoi(40);

        // R6: mask boundary, priority equal to mask blocked
        do_prio(5, 8'hFF); do_prio(9, 8'hFE); do_prio(40, 8'hFF);
        do_ack("R6 only 0xFE under mask 0xFF", g); chk(32'(g), 32'd9, "R6 mask boundary");
        do_eoi(9);
        do_mask(8'hFE);
        do_ack("R6 equal to mask blocked", g); chk(32'(g), 32'(SPUR), "R6 spurious at mask");
        // R11: line dropped before claim not offered
        do_mask(8'hFF); do_prio(5, 8'h10);
        @(negedge clk); lines_v[5] = 1'b0;
        do_ack("R11 dropped line not offered", g); chk(32'(g), 32'd9, "R11 falls to line 9");
        do_eoi(9);

        // Random traffic against the model
        for (int it = 0; it < 1500; it++) begin
            int op;
            op = int'($urandom_range(0, 9));
            case (op)
                0: begin @(negedge clk); lines_v = {$urandom, $urandom}; end
                1: do_set(int'($urandom_range(0, NW-1)), $urandom & $urandom);
                2: do_clr(int'($urandom_range(0, NW-1)), $urandom & $urandom);
                3: do_prio(int'($urandom_range(0, NL-1)), 8'($urandom));
                4: do_mask((($urandom & 3) == 0) ? int'($urandom_range(0, 255)) : 255);
                5, 6: do_ack("R9 random claim vs model", g);
                7: begin
                    int id;
                    id = int'($urandom_range(0, NL-1));
                    if (($urandom & 1) == 1) id = int'($urandom_range(0, 1023));
                    do_eoi(id);
                end
                8: chk_irq("R5 random irq vs model");
                default: if (($urandom & 15) == 0)
                    do_ctrl(($urandom & 7) != 0, ($urandom & 7) != 0);
            endcase
        end
        do_ctrl(1'b1, 1'b1);
        chk_irq("R5 final irq");
        for (int w = 0; w < NW; w++) begin
            bus_read(12'h100 + 12'(4*w), d);
            chk(d, en_word(w), "R2 final enable readback");
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule